// File: doc/BRIEF.md
# Counted Byte Block-Move Engine

This block copies a run of bytes from one region of a byte-addressed memory to another. A single-cycle start strobe loads three operands: a 16-bit source pointer, a 16-bit destination pointer and an 8-bit byte count. The engine first tests the count. It then moves one byte per iteration over a single synchronous memory port. Each iteration reads the source, writes the byte to the destination, steps both pointers up by one and lowers the count by one. The copy stops when the count reaches zero.

The run takes a fixed number of cycles: four per byte plus nine fixed cycles of setup and wind-down. A controller can therefore budget the time exactly from the starting count. After the run, the advanced pointers and the zero count stay on the result outputs, so the caller can chain a further copy from where this one ended.

Top module: `blkmove_engine`

## Requirements
- R1: A start with a count of zero makes no memory access (neither `mem_re_o` nor `mem_we_o` is ever high), and the run still completes in 9 busy cycles with `done_o`.
- R2: For byte k (k = 0..n-1), the engine raises `mem_re_o` with `mem_addr_o` = source+k. Two cycles later it raises `mem_we_o` with `mem_addr_o` = destination+k and `mem_wdata_o` equal to the byte the memory returned in the cycle after the read.
- R3: After each byte both pointer results rise by one and the count result falls by one. At completion `src_o` = source+n, `dst_o` = destination+n and `cnt_o` = 0.
- R4: Both pointers wrap modulo 2^16 (0xFFFF steps to 0x0000) with no other effect.
- R5: `busy_o` is high for exactly 4n+9 consecutive cycles, n being the loaded count. `done_o` is a one-cycle pulse in the first cycle after `busy_o` falls.
- R6: A start strobe that arrives while `busy_o` is high is ignored: operands, memory traffic, timing and results are those of the run already in progress.
- R7: The memory read and write strobes are never high in the same cycle, and neither is high while `busy_o` is low.
- R8: After reset `busy_o`, `done_o`, `mem_re_o` and `mem_we_o` are 0, and `src_o`, `dst_o` and `cnt_o` are 0.
- R9: After completion `src_o`, `dst_o` and `cnt_o` hold their final values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only while idle |
| src_i | input | 16 | Starting source pointer |
| dst_i | input | 16 | Starting destination pointer |
| cnt_i | input | 8 | Number of bytes to move |
| mem_addr_o | output | 16 | Memory address for the current access |
| mem_re_o | output | 1 | Read strobe; data is returned on the next cycle |
| mem_rdata_i | input | 8 | Read data from memory, one cycle after `mem_re_o` |
| mem_we_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | One-cycle completion pulse |
| src_o | output | 16 | Current or final source pointer |
| dst_o | output | 16 | Current or final destination pointer |
| cnt_o | output | 8 | Current or final remaining count |

## Verification
The bench drives a zero count. An engine that ran the loop body before testing the count would issue a stray read and write and run 4 cycles long. A run across 0xFFFF would show an engine that carries into a seventeenth bit or stops at the top of memory, because the observed write addresses would diverge from the wrapped ones. A full 255-byte copy checks the cycle budget at its largest value, where an off-by-one in the per-byte or fixed cost becomes obvious. A start pulse with different operands fired mid-run would show a restart or a mixed-up operand set as unexpected addresses and a wrong cycle count.

// File: rtl/blkmove_pkg.sv
package blkmove_pkg;

  // Cycles spent on every transferred byte.
  parameter int unsigned MV_BYTE_CYC = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_RADDR,
    ST_RDATA,
    ST_WRITE,
    ST_UPDATE,
    ST_FINISH
  } mv_state_e;

  // Total busy cycles of one run of n bytes.
  function automatic int unsigned mv_total_states(input int unsigned n,
                                                  input int unsigned per,
                                                  input int unsigned fixed);
    return per * n + fixed;
  endfunction

endpackage

// File: rtl/blkmove_ctrl.sv
module blkmove_ctrl
  import blkmove_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SETUP_CYC  = 5,
  parameter int FINISH_CYC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cnt_q_i,
  output mv_state_e        state_o,
  output logic             ev_load_o,
  output logic             ev_step_o,
  output logic             busy_o,
  output logic             done_o
);

  localparam int PH_MAX = (SETUP_CYC > FINISH_CYC) ? SETUP_CYC : FINISH_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int FIXED  = SETUP_CYC + FINISH_CYC;
  localparam int RUN_W  = CNT_W + 6;

  mv_state_e       st_q, st_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic            done_q;
  logic            ev_finish;
  logic            cnt_zero;
  logic            cnt_last;

  function automatic logic is_last(input logic [CNT_W-1:0] c);
    return c == CNT_W'(1);
  endfunction

  assign cnt_zero  = (cnt_q_i == '0);
  assign cnt_last  = is_last(cnt_q_i);
  assign ev_load_o = (st_q == ST_IDLE) && start_i;
  assign ev_step_o = (st_q == ST_UPDATE);
  assign ev_finish = (st_q == ST_FINISH) && (ph_q == '0);
  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign state_o   = st_q;

  always_comb begin
    st_d = st_q;
    ph_d = ph_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d = ST_SETUP;
          ph_d = PH_W'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (ph_q == '0) begin
          if (cnt_zero) begin
            st_d = ST_FINISH;
            ph_d = PH_W'(FINISH_CYC - 1);
          end else begin
            st_d = ST_RADDR;
          end
        end else begin
          ph_d = ph_q - 1'b1;
        end
      end
      ST_RADDR: st_d = ST_RDATA;
      ST_RDATA: st_d = ST_WRITE;
      ST_WRITE: st_d = ST_UPDATE;
      ST_UPDATE: begin
        if (cnt_last) begin
          st_d = ST_FINISH;
          ph_d = PH_W'(FINISH_CYC - 1);
        end else begin
          st_d = ST_RADDR;
        end
      end
      ST_FINISH: begin
        if (ph_q == '0) st_d = ST_IDLE;
        else            ph_d = ph_q - 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      done_q <= ev_finish;
    end
  end

  // Run-length tracking used only by the assertions below.
  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] n_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= '0;
      n_q   <= '0;
    end else if (ev_load_o) begin
      run_q <= '0;
      n_q   <= cnt_i;
    end else if (busy_o) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R5: the run ends after exactly 4n+9 busy cycles
  a_r5_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    ev_finish |-> ((32'(run_q) + 32'd1) ==
                   mv_total_states(32'(n_q), MV_BYTE_CYC, 32'(FIXED))));

  // R5: done is a single-cycle pulse that follows the last busy cycle
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

endmodule

// File: rtl/blkmove_regs.sv
module blkmove_regs #(
  parameter int PTR_W = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_load_i,
  input  logic             ev_step_i,
  input  logic [PTR_W-1:0] src_i,
  input  logic [PTR_W-1:0] dst_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [PTR_W-1:0] src_q,
  output logic [PTR_W-1:0] dst_q,
  output logic [CNT_W-1:0] cnt_q
);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] c);
    return c - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (ev_load_i) begin
      src_q <= src_i;
      dst_q <= dst_i;
      cnt_q <= cnt_i;
    end else if (ev_step_i) begin
      src_q <= ptr_inc(src_q);
      dst_q <= ptr_inc(dst_q);
      cnt_q <= cnt_dec(cnt_q);
    end
  end

  // R3: operands captured on an accepted start
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    ev_load_i |=> (src_q == $past(src_i)) && (dst_q == $past(dst_i)) &&
                  (cnt_q == $past(cnt_i)));

  // R3/R4: one step moves both pointers up (wrapping) and the count down
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step_i |=> (src_q == PTR_W'($past(src_q) + 1'b1)) &&
                  (dst_q == PTR_W'($past(dst_q) + 1'b1)) &&
                  (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

  // R6/R9: without a load or step the results are frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_load_i && !ev_step_i) |=> $stable(src_q) && $stable(dst_q) &&
                                   $stable(cnt_q));

  // R1: a step never happens on a zero count
  a_r1_no_step_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ev_step_i |-> (cnt_q != '0));

endmodule

// File: rtl/blkmove_memif.sv
module blkmove_memif
  import blkmove_pkg::*;
#(
  parameter int PTR_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mv_state_e         state_i,
  input  logic [PTR_W-1:0]  src_q_i,
  input  logic [PTR_W-1:0]  dst_q_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic              mem_re_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  logic [DATA_W-1:0] byte_q;
  logic              ev_capture;

  assign ev_capture  = (state_i == ST_RDATA);
  assign mem_re_o    = (state_i == ST_RADDR);
  assign mem_we_o    = (state_i == ST_WRITE);
  assign mem_addr_o  = mem_we_o ? dst_q_i : src_q_i;
  assign mem_wdata_o = byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          byte_q <= '0;
    else if (ev_capture) byte_q <= mem_rdata_i;
  end

  // R2: every write is preceded, two cycles earlier, by a read
  a_r2_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> $past(mem_re_o, 2));

  // R2: the written byte is the one the memory returned after the read
  a_r2_write_data: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> (mem_wdata_o == $past(mem_rdata_i)));

  // R7: strobes are exclusive
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re_o, mem_we_o}));

endmodule

// File: rtl/blkmove_engine.sv
module blkmove_engine
  import blkmove_pkg::*;
#(
  parameter int PTR_W      = 16,
  parameter int CNT_W      = 8,
  parameter int DATA_W     = 8,
  parameter int SETUP_CYC  = 5,
  parameter int FINISH_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [PTR_W-1:0]  src_i,
  input  logic [PTR_W-1:0]  dst_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [PTR_W-1:0]  mem_addr_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [PTR_W-1:0]  src_o,
  output logic [PTR_W-1:0]  dst_o,
  output logic [CNT_W-1:0]  cnt_o
);

  mv_state_e        state;
  logic             ev_load;
  logic             ev_step;
  logic [PTR_W-1:0] src_q;
  logic [PTR_W-1:0] dst_q;
  logic [CNT_W-1:0] cnt_q;

  blkmove_ctrl #(
    .CNT_W      (CNT_W),
    .SETUP_CYC  (SETUP_CYC),
    .FINISH_CYC (FINISH_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .cnt_i     (cnt_i),
    .cnt_q_i   (cnt_q),
    .state_o   (state),
    .ev_load_o (ev_load),
    .ev_step_o (ev_step),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  blkmove_regs #(
    .PTR_W (PTR_W),
    .CNT_W (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev_load_i (ev_load),
    .ev_step_i (ev_step),
    .src_i     (src_i),
    .dst_i     (dst_i),
    .cnt_i     (cnt_i),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q)
  );

  blkmove_memif #(
    .PTR_W  (PTR_W),
    .DATA_W (DATA_W)
  ) u_memif (
    .clk         (clk),
    .rst_n       (rst_n),
    .state_i     (state),
    .src_q_i     (src_q),
    .dst_q_i     (dst_q),
    .mem_rdata_i (mem_rdata_i),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o)
  );

  assign src_o = src_q;
  assign dst_o = dst_q;
  assign cnt_o = cnt_q;

  // R7: the memory port is quiet whenever the engine is idle
  a_r7_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!mem_re_o && !mem_we_o));

  // R6: a start during a run does not reload the operands
  a_r6_busy_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |-> !ev_load);

endmodule

// File: tb/blkmove_engine_tb.sv
module blkmove_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] src_i = '0;
  logic [15:0] dst_i = '0;
  logic [7:0]  cnt_i = '0;
  logic [15:0] mem_addr_o;
  logic        mem_re_o;
  logic [7:0]  mem_rdata_i = '0;
  logic        mem_we_o;
  logic [7:0]  mem_wdata_o;
  logic        busy_o;
  logic        done_o;
  logic [15:0] src_o;
  logic [15:0] dst_o;
  logic [7:0]  cnt_o;

  always #5 clk = ~clk;

  blkmove_engine u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .src_i       (src_i),
    .dst_i       (dst_i),
    .cnt_i       (cnt_i),
    .mem_addr_o  (mem_addr_o),
    .mem_re_o    (mem_re_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_we_o    (mem_we_o),
    .mem_wdata_o (mem_wdata_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .src_o       (src_o),
    .dst_o       (dst_o),
    .cnt_o       (cnt_o)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Memory contents are a function of the address.
  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_re_o) mem_rdata_i <= pat(mem_addr_o);
  end

  typedef struct packed {
    logic [15:0] addr;
    logic [7:0]  data;
  } wr_item_t;

  wr_item_t    exp_q[$];
  logic [15:0] exp_src, exp_dst, rd_exp;
  int          exp_n    = 0;
  int          reads    = 0;
  int          busy_cyc = 0;
  bit          done_seen = 1'b0;

  // Monitor: compares memory traffic and results against the scoreboard.
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_re_o && mem_we_o)
        check(1'b0, "R7 read and write together", 32'd1, 32'd0);
      if (!busy_o && (mem_re_o || mem_we_o))
        check(1'b0, "R7 access while idle", {30'd0, mem_re_o, mem_we_o}, 32'd0);
      if (mem_re_o) begin
        check(mem_addr_o == rd_exp, "R2/R4 read address", {16'd0, mem_addr_o}, {16'd0, rd_exp});
        rd_exp = rd_exp + 16'd1;
        reads++;
      end
      if (mem_we_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1/R2 unexpected write", {16'd0, mem_addr_o}, 32'd0);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          check(mem_addr_o == it.addr, "R2/R4 write address", {16'd0, mem_addr_o}, {16'd0, it.addr});
          check(mem_wdata_o == it.data, "R2 write data", {24'd0, mem_wdata_o}, {24'd0, it.data});
        end
      end
      if (busy_o) busy_cyc++;
      if (done_o) begin
        check(!busy_o, "R5 done while busy", 32'd1, 32'd0);
        check(busy_cyc == 4 * exp_n + 9, "R5 busy cycles", busy_cyc, 4 * exp_n + 9);
        check(reads == exp_n, "R1/R2 read count", reads, exp_n);
        check(exp_q.size() == 0, "R2 writes missing", exp_q.size(), 32'd0);
        check(src_o == exp_src, "R3/R4 final source", {16'd0, src_o}, {16'd0, exp_src});
        check(dst_o == exp_dst, "R3/R4 final destination", {16'd0, dst_o}, {16'd0, exp_dst});
        check(cnt_o == 8'd0, "R3 final count", {24'd0, cnt_o}, 32'd0);
        busy_cyc  = 0;
        done_seen = 1'b1;
      end
    end
  end

  // Driver: launches one run and queues the expected writes.
  task automatic run_copy(input logic [15:0] s, input logic [15:0] d,
                          input logic [7:0] n, input bit poke);
    int waited;
    for (int i = 0; i < int'(n); i++) begin
      wr_item_t it;
      it.addr = d + 16'(i);
      it.data = pat(s + 16'(i));
      exp_q.push_back(it);
    end
    exp_n     = int'(n);
    exp_src   = s + 16'(n);
    exp_dst   = d + 16'(n);
    rd_exp    = s;
    reads     = 0;
    done_seen = 1'b0;
    start_i = 1'b1; src_i = s; dst_i = d; cnt_i = n;
    @(negedge clk);
    start_i = 1'b0; src_i = 16'hDEAD; dst_i = 16'hBEEF; cnt_i = 8'h77;
    if (poke) begin
      // R6: a second start with other operands, mid-run
      repeat (7) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    waited = 0;
    while (!done_seen && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    if (!done_seen) begin
      check(1'b0, "R5 watchdog: no done", waited, 4 * exp_n + 9);
      exp_q.delete();
    end
    // R9: results hold and done stays low afterwards
    repeat (3) @(negedge clk);
    #1;
    check(src_o == exp_src, "R9 source held", {16'd0, src_o}, {16'd0, exp_src});
    check(dst_o == exp_dst, "R9 destination held", {16'd0, dst_o}, {16'd0, exp_dst});
    check(cnt_o == 8'd0, "R9 count held", {24'd0, cnt_o}, 32'd0);
    check(!done_o && !busy_o, "R5 done is one pulse", {30'd0, done_o, busy_o}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state
    check(!busy_o && !done_o, "R8 busy/done after reset", {30'd0, busy_o, done_o}, 32'd0);
    check(!mem_re_o && !mem_we_o, "R8 strobes after reset", {30'd0, mem_re_o, mem_we_o}, 32'd0);
    check(src_o == 16'd0 && dst_o == 16'd0 && cnt_o == 8'd0, "R8 results after reset",
          {src_o, dst_o[15:8], cnt_o}, 32'd0);
    @(negedge clk);

    run_copy(16'h1000, 16'h2000, 8'd3, 1'b0);     // R2, R3
    run_copy(16'h0100, 16'h0200, 8'd0, 1'b0);     // R1 zero count
    run_copy(16'hFFFD, 16'hFFFE, 8'd5, 1'b0);     // R4 wrap
    run_copy(16'h3000, 16'h4000, 8'd1, 1'b0);     // single byte
    run_copy(16'h5000, 16'h6000, 8'd6, 1'b1);     // R6 start while busy
    run_copy(16'h0000, 16'h8000, 8'd255, 1'b0);   // R5 largest count

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  // Global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule